// File: doc/BRIEF.md
# Dual-Clock FIFO with Stop Controls

This block moves data words from one clock domain to another through an inferred dual-port memory. The write side owns its address counter, the full flag and an almost-full flag. The read side owns its address counter, the empty flag and an almost-empty flag. Both counters cross to the other domain as Gray codes through a short chain of flip-flops. Each side compares its own binary pointer with the decoded remote pointer. Each pointer carries one wrap bit above the address, so occupancy is the pointer difference modulo twice the depth.

Each side also has a stop input. With the stop input high, the side blocks while its flag is raised, which is ordinary FIFO behaviour. With it low, the counter keeps stepping past the flag. On the read side this replays stored words again and again with no new writes. On the write side the counter runs past full and overwrites the oldest slot. The almost-full and almost-empty thresholds are runtime inputs.

Top module: `dcfifo_stop`

## Requirements
- R1: While a side's reset is high, and on the first cycle after it, that side's pointer is zero. After reset, rempty and ralmost_empty read 1, wfull and walmost_full read 0, and rdata reads 0.
- R2: Words are read out in the order they were written, including runs long enough that the address counters pass DEPTH-1 and wrap to 0.
- R3: wfull rises on the write edge that stores the DEPTH-th unread word. While wfull and wfull_stop are both high, a write leaves the pointer and the memory untouched, so that word is never read.
- R4: While rempty and rempty_stop are both high, a read leaves rdata and the read pointer unchanged, and rempty stays 1.
- R5: After a read removes the full condition, wfull stays 1 through the first wclk rising edge that follows and drops on the second. A write attempted on either of those edges is blocked.
- R6: After a write into an empty FIFO, rempty stays 1 through the first rclk rising edge that follows and drops on the second.
- R7: walmost_full is 1 when the write side's occupancy is at least af_level, and 0 below it.
- R8: ralmost_empty is 1 when the read side's occupancy is at most ae_level, and 0 above it.
- R9: With rempty_stop low, every read advances the read counter and returns the word at its address, even while rempty is 1. From an empty FIFO holding DEPTH words, 2*DEPTH reads return the stored words in address order twice, and rempty is 1 again afterwards.
- R10: With wfull_stop low, a write while wfull is 1 is accepted and stores into the slot at the write address, which holds the oldest unread word. wfull stays 1. The next 17 reads return the new word, the 15 words after it, and the new word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wrst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Word to store |
| wfull_stop | input | 1 | 1: writes block while full; 0: write counter runs past full |
| wfull | output | 1 | Full flag, registered in the write domain |
| walmost_full | output | 1 | Occupancy at or above af_level |
| af_level | input | LVL_W | Almost-full threshold |
| rclk | input | 1 | Read-domain clock |
| rrst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rdata | output | DW | Registered read word |
| rempty_stop | input | 1 | 1: reads block while empty; 0: read counter keeps cycling |
| rempty | output | 1 | Empty flag, registered in the read domain |
| ralmost_empty | output | 1 | Occupancy at or below ae_level |
| ae_level | input | LVL_W | Almost-empty threshold |

## Verification
The functions that can collide are a pending write and the release of the full flag by a read in the other domain. Both can land on the same wclk edge. To provoke this, the bench fills the FIFO and takes one word on the read side. It then keeps write requests going across the two wclk edges that follow, while it watches wfull at each edge. Each attempt is judged by the flag value that stood before its edge. Only accepted words enter the scoreboard, so a word that slipped in early, or one wrongly dropped, shows up as a mismatch when the FIFO is drained.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Binary to reflected-binary code on a 32-bit carrier.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected-binary code back to binary on a 32-bit carrier.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_pre
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

  // Value the last stage takes at the next edge; lets a registered flag
  // change on the same edge as the settled copy.
  generate
    if (STAGES > 1) begin : g_multi
      assign q_pre = st[STAGES-2];
    end else begin : g_single
      assign q_pre = d;
    end
  endgenerate

endmodule

// File: rtl/dcf_ptr_ctl.sv
module dcf_ptr_ctl #(
  parameter int AW    = 4,
  parameter int LVL_W = 12,
  parameter bit IS_WR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          stop,
  input  logic [LVL_W-1:0] level,
  input  logic [AW:0]   remote_q,
  input  logic [AW:0]   remote_pre,
  output logic [AW:0]   gray,
  output logic [AW-1:0] addr,
  output logic          take,
  output logic          flag,
  output logic          near
);

  localparam int  CW       = AW + 1;
  localparam logic FLAG_RST = IS_WR ? 1'b0 : 1'b1;
  localparam logic NEAR_RST = IS_WR ? 1'b0 : 1'b1;

  logic [AW:0] bin, bin_n;
  logic [AW:0] rbin_pre, rbin_q;
  logic [AW:0] occ_pre, occ_q;
  logic        flag_n, near_n;

  assign take  = req && (!flag || !stop);
  assign bin_n = bin + {{AW{1'b0}}, take};

  assign rbin_pre = CW'(dcf_pkg::from_gray(32'(remote_pre)));
  assign rbin_q   = CW'(dcf_pkg::from_gray(32'(remote_q)));

  generate
    if (IS_WR) begin : g_wr
      assign occ_pre = bin_n - rbin_pre;
      assign occ_q   = bin_n - rbin_q;
      assign flag_n  = occ_pre[AW];
      assign near_n  = 32'(occ_q) >= 32'(level);
    end else begin : g_rd
      assign occ_pre = rbin_pre - bin_n;
      assign occ_q   = rbin_q - bin_n;
      assign flag_n  = (occ_pre == '0);
      assign near_n  = 32'(occ_q) <= 32'(level);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
      flag <= FLAG_RST;
      near <= NEAR_RST;
    end else begin
      bin  <= bin_n;
      gray <= CW'(dcf_pkg::to_gray(32'(bin_n)));
      flag <= flag_n;
      near <= near_n;
    end
  end

  assign addr = bin[AW-1:0];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dcfifo_stop.sv
module dcfifo_stop #(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int LVL_W  = 12,
  parameter int STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             wfull_stop,
  output logic             wfull,
  output logic             walmost_full,
  input  logic [LVL_W-1:0] af_level,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rd_en,
  output logic [DW-1:0]    rdata,
  input  logic             rempty_stop,
  output logic             rempty,
  output logic             ralmost_empty,
  input  logic [LVL_W-1:0] ae_level
);

  logic [AW:0]   wgray, rgray;
  logic [AW:0]   w2r_q, w2r_pre;
  logic [AW:0]   r2w_q, r2w_pre;
  logic [AW-1:0] waddr, raddr;
  logic          wtake, rtake;

  dcf_sync #(.W(AW+1), .STAGES(STAGES)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(w2r_q), .q_pre(w2r_pre)
  );

  dcf_sync #(.W(AW+1), .STAGES(STAGES)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(r2w_q), .q_pre(r2w_pre)
  );

  dcf_ptr_ctl #(.AW(AW), .LVL_W(LVL_W), .IS_WR(1'b1)) u_wctl (
    .clk(wclk), .rst(wrst), .req(wr_en), .stop(wfull_stop), .level(af_level),
    .remote_q(r2w_q), .remote_pre(r2w_pre),
    .gray(wgray), .addr(waddr), .take(wtake), .flag(wfull), .near(walmost_full)
  );

  dcf_ptr_ctl #(.AW(AW), .LVL_W(LVL_W), .IS_WR(1'b0)) u_rctl (
    .clk(rclk), .rst(rrst), .req(rd_en), .stop(rempty_stop), .level(ae_level),
    .remote_q(w2r_q), .remote_pre(w2r_pre),
    .gray(rgray), .addr(raddr), .take(rtake), .flag(rempty), .near(ralmost_empty)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(wtake), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(rrst), .re(rtake), .raddr(raddr), .rdata(rdata)
  );

endmodule

// File: rtl/dcfifo_stop_chk.sv
module dcfifo_stop_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          wrst,
  input logic          wr_en,
  input logic          wfull_stop,
  input logic          wfull,
  input logic [AW:0]   wgray,
  input logic          rclk,
  input logic          rrst,
  input logic          rd_en,
  input logic          rempty_stop,
  input logic          rempty,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] rdata
);

  // R1: reset state on each side
  assert_wreset_R1: assert property (@(posedge wclk)
    wrst |=> (!wfull && wgray == '0))
    else $error("write-side reset state wrong");

  assert_rreset_R1: assert property (@(posedge rclk)
    rrst |=> (rempty && rgray == '0))
    else $error("read-side reset state wrong");

  // R2: ordered transfer relies on one-bit pointer steps across domains
  assert_wgray_step_R2: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1)
    else $error("write pointer moved more than one code bit");

  assert_rgray_step_R2: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1)
    else $error("read pointer moved more than one code bit");

  // R3: blocked write while full
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && wfull && wfull_stop) |=> $stable(wgray))
    else $error("write pointer advanced while full");

  // R4: blocked read while empty
  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (rrst)
    (rd_en && rempty && rempty_stop) |=> ($stable(rgray) && $stable(rdata)))
    else $error("read side changed while empty");

  // R9: read counter always steps when the stop is off
  assert_replay_step_R9: assert property (@(posedge rclk) disable iff (rrst)
    (rd_en && !rempty_stop) |=> !$stable(rgray))
    else $error("read pointer held with stop off");

  // R10: write counter always steps when the stop is off
  assert_overrun_step_R10: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && !wfull_stop) |=> !$stable(wgray))
    else $error("write pointer held with stop off");

endmodule

bind dcfifo_stop dcfifo_stop_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wfull_stop(wfull_stop),
  .wfull(wfull), .wgray(wgray),
  .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rempty_stop(rempty_stop),
  .rempty(rempty), .rgray(rgray), .rdata(rdata)
);

// File: tb/sim_dcfifo_stop.sv
`timescale 1ns/100ps
module sim_dcfifo_stop;

  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int LW    = 12;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst = 1'b1, rrst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          wfull_stop = 1'b1, rempty_stop = 1'b1;
  logic [LW-1:0] af_level = LW'(12), ae_level = LW'(3);
  logic          wfull, walmost_full, rempty, ralmost_empty;
  logic [DW-1:0] rdata;

  logic [DW-1:0] expq [$];
  logic [DW-1:0] vals [DEPTH];
  int    checks = 0, fails = 0;
  bit    pend = 1'b0, done = 1'b0;
  string mtag = "R2";

  dcfifo_stop #(.DW(DW), .AW(AW), .LVL_W(LW)) u0 (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wdata(wdata),
    .wfull_stop(wfull_stop), .wfull(wfull), .walmost_full(walmost_full),
    .af_level(af_level),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rdata(rdata),
    .rempty_stop(rempty_stop), .rempty(rempty), .ralmost_empty(ralmost_empty),
    .ae_level(ae_level)
  );

  // 200 MHz write clock; read clock 7 ns, phase-shifted so edges never meet
  initial forever #2.5 wclk = ~wclk;
  initial begin #1.3; forever #3.5 rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: a read accepted at a posedge is compared at the next negedge
  always @(negedge rclk) begin
    logic [DW-1:0] e;
    if (pend) begin
      if (expq.size() == 0) chk(1'b0, {mtag, " unexpected word"}, int'(rdata), -1);
      else begin
        e = expq.pop_front();
        chk(rdata == e, {mtag, " read data"}, int'(rdata), int'(e));
      end
    end
    pend = rd_en && (!rempty || !rempty_stop) && !rrst;
  end

  task automatic wsync(); @(posedge wclk); #1; endtask
  task automatic rsync(); @(posedge rclk); #1; endtask
  task automatic ridle(input int n); repeat (n) @(posedge rclk); #1; endtask

  // Driver: called just after a wclk edge; scoreboards the word if accepted
  task automatic put(input logic [DW-1:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge wclk);
    if (!wfull || !wfull_stop) expq.push_back(d);
    @(posedge wclk); #1;
    wr_en = 1'b0;
  endtask

  task automatic get();
    rd_en = 1'b1;
    @(posedge rclk); #1;
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    wr_en = 1'b0; rd_en = 1'b0; wrst = 1'b1; rrst = 1'b1;
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    expq.delete();
    @(posedge wclk); #1 wrst = 1'b0;
    @(posedge rclk); #1 rrst = 1'b0;
    ridle(3);
  endtask

  task automatic drain();
    int guard = 0;
    rsync();
    while (!rempty && guard < 4*DEPTH) begin get(); guard++; end
    ridle(2);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(rempty == 1'b1, "R1 rempty", int'(rempty), 1);
    chk(ralmost_empty == 1'b1, "R1 ralmost_empty", int'(ralmost_empty), 1);
    chk(rdata == '0, "R1 rdata", int'(rdata), 0);
    chk(wfull == 1'b0, "R1 wfull", int'(wfull), 0);
    chk(walmost_full == 1'b0, "R1 walmost_full", int'(walmost_full), 0);

    // R6 empty release latency
    wsync();
    wr_en = 1'b1; wdata = 8'h11;
    @(posedge wclk); #0.1 wr_en = 1'b0;
    expq.push_back(8'h11);
    @(posedge rclk); #0.2;
    chk(rempty == 1'b1, "R6 empty after first rclk edge", int'(rempty), 1);
    @(posedge rclk); #0.2;
    chk(rempty == 1'b0, "R6 empty after second rclk edge", int'(rempty), 0);
    rsync(); get(); ridle(2);

    // R2 order across address wrap
    for (int r = 0; r < 3; r++) begin
      wsync();
      for (int i = 0; i < 10; i++) put(8'(8'h20 + r*40 + i));
      ridle(4);
      rsync();
      for (int i = 0; i < 10; i++) get();
      ridle(2);
    end
    chk(expq.size() == 0, "R2 words left unread", expq.size(), 0);

    // R3, R7 fill from zero
    do_reset();
    wsync();
    for (int i = 0; i < DEPTH; i++) begin
      put(8'(8'h30 + i));
      if (i == 10) chk(walmost_full == 1'b0, "R7 below threshold", int'(walmost_full), 0);
      if (i == 11) chk(walmost_full == 1'b1, "R7 at threshold", int'(walmost_full), 1);
      if (i == DEPTH-2) chk(wfull == 1'b0, "R3 one slot left", int'(wfull), 0);
      if (i == DEPTH-1) chk(wfull == 1'b1, "R3 full on last word", int'(wfull), 1);
    end
    put(8'hEE);
    chk(expq.size() == DEPTH, "R3 write while full refused", expq.size(), DEPTH);
    ridle(4);
    chk(ralmost_empty == 1'b0, "R8 full FIFO not almost empty", int'(ralmost_empty), 0);

    // R5 full release latency, with writes attempted across the release
    rsync();
    rd_en = 1'b1;
    @(posedge rclk); #0.1 rd_en = 1'b0;
    fork
      begin
        @(posedge wclk); #0.2;
        chk(wfull == 1'b1, "R5 full after first wclk edge", int'(wfull), 1);
        @(posedge wclk); #0.2;
        chk(wfull == 1'b0, "R5 full after second wclk edge", int'(wfull), 0);
      end
      begin
        @(posedge wclk); #1;
        put(8'hA0);
        put(8'hA1);
      end
    join
    ridle(4);
    drain();
    chk(expq.size() == 0, "R3 blocked words absent, order kept", expq.size(), 0);

    // R8 almost-empty while draining, R4 read while empty
    do_reset();
    wsync();
    for (int i = 0; i < DEPTH; i++) begin vals[i] = 8'(8'h40 + i); put(vals[i]); end
    ridle(4);
    rsync();
    for (int k = 0; k < DEPTH; k++) begin
      get();
      if (k == DEPTH-5) chk(ralmost_empty == 1'b0, "R8 four left", int'(ralmost_empty), 0);
      if (k == DEPTH-4) chk(ralmost_empty == 1'b1, "R8 three left", int'(ralmost_empty), 1);
    end
    ridle(2);
    begin
      logic [DW-1:0] held;
      held = rdata;
      rsync(); get(); ridle(2);
      chk(rdata == held, "R4 rdata held on empty read", int'(rdata), int'(held));
      chk(rempty == 1'b1, "R4 still empty", int'(rempty), 1);
    end

    // R9 replay with read stop off
    rempty_stop = 1'b0;
    mtag = "R9";
    for (int k = 0; k < 2*DEPTH; k++) expq.push_back(vals[k % DEPTH]);
    rsync();
    for (int k = 0; k < 2*DEPTH; k++) get();
    ridle(2);
    chk(expq.size() == 0, "R9 replay words missing", expq.size(), 0);
    chk(rempty == 1'b1, "R9 empty after two laps", int'(rempty), 1);
    rempty_stop = 1'b1;
    mtag = "R2";

    // R10 overwrite past full with write stop off
    do_reset();
    wsync();
    for (int i = 0; i < DEPTH; i++) begin vals[i] = 8'(8'h80 + i); put(vals[i]); end
    chk(wfull == 1'b1, "R10 full before overrun", int'(wfull), 1);
    wfull_stop = 1'b0;
    put(8'h5A);
    wfull_stop = 1'b1;
    chk(wfull == 1'b1, "R10 full after overrun", int'(wfull), 1);
    expq.delete();
    expq.push_back(8'h5A);
    for (int i = 1; i < DEPTH; i++) expq.push_back(vals[i]);
    expq.push_back(8'h5A);
    mtag = "R10";
    ridle(4);
    drain();
    chk(expq.size() == 0, "R10 overrun sequence incomplete", expq.size(), 0);
    mtag = "R2";

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule